// File: doc/BRIEF.md
# Three-Wire Tuning Word Loader

This block takes a 24-bit tuning control word from a host controller over a three-wire serial link. The link has a frame strobe, a bit clock and a data line, and all three are asynchronous to the system clock. Each wire passes through a two-stage synchronizer. Edges are then found on the synchronized copies. While the strobe is high, every rising edge of the bit clock shifts one data bit in, least significant bit first.

When the strobe falls, the shifted word is moved into a holding register, but only if exactly 24 bit clocks arrived during the frame. The holding register is decoded into these fields:
- a 14-bit divisor,
- two test bits, with a flag raised when either of them is set,
- three band-control bits,
- a time-base enable,
- a 3-bit reference-rate select,
- a high/low input select.

Nearby divider and reference logic uses these fields. Every serial transfer is ignored until an oscillator-ready input is high.

Top module: `ser_ctrl_loader`

## Requirements
- R1: After synchronous reset every decoded field and the test flag are 0.
- R2: A data bit is taken only on a rising edge of the bit clock while the strobe is high. Bit-clock pulses seen while the strobe is low change nothing.
- R3: The first 14 bits received (word bits 0..13) form the divisor, with the first bit as divisor bit 0.
- R4: Word bits 14 and 15 are the test bits. The flag `test_err` is 1 exactly when either of them is 1 in the committed word.
- R5: Word bits 16..18 are the band bits, bit 19 is the time-base enable, and bits 20..22 are the reference select, each with its lowest bit received first.
- R6: Word bit 23, the last bit received, is the input select: 1 selects the high-band input and 0 the low-band input.
- R7: A frame commits only when exactly 24 bit-clock rising edges came during it. With 23 or 25 edges, all outputs keep their values.
- R8: While `xtal_ok` is low, frames are ignored and the outputs do not change.
- R9: The outputs take the new word on the third system-clock edge after the strobe falls at the pin, and they are stable on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_ok | input | 1 | Oscillator-ready indication, in the clk domain |
| ser_en | input | 1 | Serial frame strobe (asynchronous) |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| divisor | output | 14 | Committed divisor |
| test_bits | output | 2 | Committed test bits |
| test_err | output | 1 | High when a committed test bit is nonzero |
| band | output | 3 | Committed band-control bits |
| tbase_en | output | 1 | Committed time-base enable |
| ref_sel | output | 3 | Committed reference-rate select |
| hi_band_sel | output | 1 | Committed input select (1 = high band) |

## Verification
Any change on a serial pin is seen by the edge detector after two clk edges and acted on at the third. The outputs therefore change three clk edges after the strobe falls. The bench drives the pins right after a falling clk edge and holds each serial phase for four clocks. It waits six clocks after a frame before comparing the fields. In one frame it also samples exactly two and three edges after the strobe fall, so it can see the old word and then the new one. Rejected frames are checked by reading the outputs after the settle delay, before the next frame starts.

// File: rtl/loader_pkg.sv
package loader_pkg;
  localparam int DIV_W  = 14;
  localparam int TST_W  = 2;
  localparam int BND_W  = 3;
  localparam int REF_W  = 3;
  localparam int WORD_W = DIV_W + TST_W + BND_W + 1 + REF_W + 1;

  // Packed MSB-first, so div[0] sits at word bit 0 (first bit received).
  typedef struct packed {
    logic             hi_sel;
    logic [REF_W-1:0] ref_sel;
    logic             tbase;
    logic [BND_W-1:0] band;
    logic [TST_W-1:0] test;
    logic [DIV_W-1:0] div;
  } ctl_word_t;
endpackage

// File: rtl/loader_sync.sv
module loader_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar w = 0; w < WIDTH; w++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) chain[w] <= '0;
      else     chain[w] <= {chain[w][STAGES-2:0], async_i[w]};
    end
    assign sync_o[w] = chain[w][STAGES-1];
  end
endmodule

// File: rtl/loader_shift.sv
module loader_shift #(
  parameter int WORD_W = 24,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xtal_ok,
  input  logic              en_s,
  input  logic              sclk_s,
  input  logic              dat_s,
  output logic [WORD_W-1:0] shreg,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              commit
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic en_q, sclk_q;
  logic sclk_rise, en_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      en_q   <= en_s;
      sclk_q <= sclk_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign en_fall   = en_q & ~en_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!en_s) begin
      bit_cnt <= '0;
    end else if (sclk_rise && xtal_ok) begin
      shreg <= {dat_s, shreg[WORD_W-1:1]};
      if (bit_cnt != OVER) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign commit = en_fall && xtal_ok && (bit_cnt == FULL);
endmodule

// File: rtl/loader_hold.sv
module loader_hold
  import loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [WORD_W-1:0] shreg,
  output ctl_word_t         held,
  output logic              test_err
);
  ctl_word_t incoming;
  assign incoming = ctl_word_t'(shreg);

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= '0;
      test_err <= 1'b0;
    end else if (commit) begin
      held     <= incoming;
      test_err <= |incoming.test;
    end
  end
endmodule

// File: rtl/ser_ctrl_loader.sv
module ser_ctrl_loader
  import loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xtal_ok,
  input  logic             ser_en,
  input  logic             ser_clk,
  input  logic             ser_dat,
  output logic [DIV_W-1:0] divisor,
  output logic [TST_W-1:0] test_bits,
  output logic             test_err,
  output logic [BND_W-1:0] band,
  output logic             tbase_en,
  output logic [REF_W-1:0] ref_sel,
  output logic             hi_band_sel
);
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic [2:0]        pins_s;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              commit;
  ctl_word_t         held;

  loader_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_dat, ser_clk, ser_en}),
    .sync_o  (pins_s)
  );

  loader_shift #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .xtal_ok (xtal_ok),
    .en_s    (pins_s[0]),
    .sclk_s  (pins_s[1]),
    .dat_s   (pins_s[2]),
    .shreg   (shreg),
    .bit_cnt (bit_cnt),
    .commit  (commit)
  );

  loader_hold u_hold (
    .clk      (clk),
    .rst      (rst),
    .commit   (commit),
    .shreg    (shreg),
    .held     (held),
    .test_err (test_err)
  );

  assign divisor     = held.div;
  assign test_bits   = held.test;
  assign band        = held.band;
  assign tbase_en    = held.tbase;
  assign ref_sel     = held.ref_sel;
  assign hi_band_sel = held.hi_sel;
endmodule

// File: rtl/loader_chk.sv
module loader_chk #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              xtal_ok,
  input logic              commit,
  input logic [WORD_W-1:0] shreg,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [13:0]       divisor,
  input logic [1:0]        test_bits,
  input logic              test_err,
  input logic [2:0]        band,
  input logic              hi_band_sel
);
  // R1
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (divisor == '0 && band == '0 && !test_err && !hi_band_sel));

  // R7
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(WORD_W + 1));

  // R9
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(divisor) && $stable(band) && $stable(hi_band_sel)));

  // R8
  assert_no_load_unready_R8: assert property (@(posedge clk) disable iff (rst)
    !xtal_ok |=> $stable(divisor));

  // R4
  assert_test_flag_R4: assert property (@(posedge clk) disable iff (rst)
    test_err == (|test_bits));

  // R6
  assert_select_last_bit_R6: assert property (@(posedge clk) disable iff (rst)
    commit |=> (hi_band_sel == $past(shreg[WORD_W-1])));
endmodule

bind ser_ctrl_loader loader_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .xtal_ok     (xtal_ok),
  .commit      (commit),
  .shreg       (shreg),
  .bit_cnt     (bit_cnt),
  .divisor     (divisor),
  .test_bits   (test_bits),
  .test_err    (test_err),
  .band        (band),
  .hi_band_sel (hi_band_sel)
);

// File: tb/ser_ctrl_loader_tb.sv
module ser_ctrl_loader_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xtal_ok = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [13:0] divisor;
  logic [1:0]  test_bits;
  logic        test_err;
  logic [2:0]  band;
  logic        tbase_en;
  logic [2:0]  ref_sel;
  logic        hi_band_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [23:0] exp_w = '0;

  always #2.5 clk = ~clk;

  ser_ctrl_loader u_dut (
    .clk(clk), .rst(rst), .xtal_ok(xtal_ok),
    .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .divisor(divisor), .test_bits(test_bits), .test_err(test_err),
    .band(band), .tbase_en(tbase_en), .ref_sel(ref_sel),
    .hi_band_sel(hi_band_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Ends with strobe driven low just after a falling clk edge.
  task automatic frame(input logic [23:0] w, input int nbits, input bit stray);
    if (stray) begin
      ser_dat = 1'b1;
      for (int k = 0; k < 2; k++) begin
        ser_clk = 1'b1; wait_n(4);
        ser_clk = 1'b0; wait_n(4);
      end
    end
    ser_en = 1'b1; wait_n(4);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = w[i % 24]; wait_n(4);
      ser_clk = 1'b1;      wait_n(4);
      ser_clk = 1'b0;
    end
    wait_n(4);
    ser_en = 1'b0;
  endtask

  task automatic check_all(input string tag);
    chk({"R3 divisor ", tag}, 32'(divisor), 32'(exp_w[13:0]));
    chk({"R4 test bits ", tag}, 32'(test_bits), 32'(exp_w[15:14]));
    chk({"R4 test flag ", tag}, 32'(test_err), 32'(exp_w[15] | exp_w[14]));
    chk({"R5 band ", tag}, 32'(band), 32'(exp_w[18:16]));
    chk({"R5 time base ", tag}, 32'(tbase_en), 32'(exp_w[19]));
    chk({"R5 ref select ", tag}, 32'(ref_sel), 32'(exp_w[22:20]));
    chk({"R6 input select ", tag}, 32'(hi_band_sel), 32'(exp_w[23]));
  endtask

  task automatic good_frame(input logic [23:0] w, input string tag);
    frame(w, 24, 1'b0);
    wait_n(6);
    exp_w = w;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    check_all("after reset R1");

    // R8: frame before the oscillator is ready is ignored
    frame(24'hFFFFFF, 24, 1'b0);
    wait_n(6);
    check_all("unready R8");
    xtal_ok = 1'b1;
    wait_n(2);

    // R3 R4 R5 R6: walking one across every word bit
    for (int b = 0; b < 24; b++) good_frame(24'h1 << b, "walk");
    good_frame(24'hFFFFFF, "ones");
    good_frame(24'h000000, "zeros");
    good_frame(24'h3A53EF, "mixed");
    good_frame(24'h5A5A5A, "alt");

    // R2: stray bit clocks with the strobe low must not shift
    frame(24'h8C4091, 24, 1'b1);
    wait_n(6);
    exp_w = 24'h8C4091;
    check_all("stray R2");

    // R7: short and long frames rejected
    frame(24'h123456, 23, 1'b0);
    wait_n(6);
    check_all("23 bits R7");
    frame(24'h654321, 25, 1'b0);
    wait_n(6);
    check_all("25 bits R7");

    // R9: old value two edges after the strobe falls, new value at the third
    frame(24'hA5C3F0, 24, 1'b0);
    wait_n(2);
    chk("R9 before third edge", 32'(divisor), 32'(exp_w[13:0]));
    wait_n(1);
    exp_w = 24'hA5C3F0;
    chk("R9 at third edge", 32'(divisor), 32'(exp_w[13:0]));
    wait_n(4);
    check_all("latency R9");

    // R8 again: dropping ready mid-run blocks a later frame
    xtal_ok = 1'b0;
    frame(24'h0F0F0F, 24, 1'b0);
    wait_n(6);
    check_all("ready low R8");

    // R1: reset clears committed fields
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    exp_w = '0;
    wait_n(1);
    check_all("re-reset R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule